// File: doc/BRIEF.md
# Wrap Burst Memory Address Sequencer

This block takes a wrapping burst request from a bus master and turns it into word addresses for an external NOR flash or pseudo-static RAM. A request carries a byte start address, a beat count and the memory's data width. It also carries the memory-side wrap length, a wrap enable and a flag that selects synchronous or asynchronous access. The block then presents one word address per beat. It flags the beats on which an address must be strobed into the memory, and moves to the next beat on each cycle where the memory signals ready.

The beat count is the master's wrap length. If memory wrapping is enabled and its length equals the beat count, the whole request goes out as one wrapped burst, and the block raises `wrap_mode` so the memory wraps by itself. If not, the block splits the request into two linear bursts. The first runs from the start word to the end of the aligned window. The second starts at the window base and covers the remaining beats. A start word that is already aligned needs only one linear burst.

Top module: `wrap_burst_seq`

## Requirements
- R1: The word address is the byte address for `mem_width`=0 (8-bit), the byte address shifted right by one for `mem_width`=1 (16-bit), and shifted right by two for `mem_width`=2 (32-bit).
- R2: `wrap_size` codes 0, 1 and 2 select a memory wrap of 8, 16 and 32 words. When `wrap_en` is high and that length equals `req_beats`, the block sends one burst with `wrap_mode` high. Beat i then carries base + ((offset + i) mod beats), where base is the word address aligned down to a multiple of `req_beats` and offset is the word address minus base.
- R3: Otherwise `wrap_mode` is low and the same address order is sent as two linear bursts. The first covers offset to beats-1 and the second covers 0 to offset-1, both relative to base.
- R4: When offset is zero and memory wrap is not used, the request is a single linear burst of `req_beats` words starting at the start word.
- R5: In asynchronous mode (`sync_mode`=0), `addr_strobe` is high on every beat.
- R6: In synchronous mode, `addr_strobe` is high only on the first beat of each burst: the first beat of the request, plus the beat at the window base in the split case.
- R7: A beat completes only in a cycle where `beat_valid` and `mem_ready` are both high. While `mem_ready` is low, the address, the strobe and the valid flag hold.
- R8: `done` is high for exactly one cycle, the cycle after the final beat completes, and `busy` is low in that cycle. Exactly `req_beats` beats complete per request.
- R9: A request made while `busy` is high is ignored. It adds no beats and does not change the address, strobe or wrap mode of the burst in progress.
- R10: After reset, `busy`, `beat_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Burst request, sampled when idle |
| req_addr | input | 26 | Byte start address |
| req_beats | input | 6 | Beat count, a power of two from 1 to 32 |
| mem_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit memory |
| wrap_en | input | 1 | Memory-side wrap allowed |
| wrap_size | input | 2 | Memory wrap length: 0 = 8, 1 = 16, 2 = 32 words |
| sync_mode | input | 1 | 1 = synchronous burst, 0 = asynchronous |
| mem_ready | input | 1 | Memory accepts the current beat |
| busy | output | 1 | Request in progress |
| mem_addr | output | 26 | Word address of the current beat |
| addr_strobe | output | 1 | Address must be latched by the memory on this beat |
| beat_valid | output | 1 | Current beat is valid |
| wrap_mode | output | 1 | Memory should wrap internally for this burst |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench sends start offsets that are zero, in the middle of the window and at the last word. A design that gets the boundary wrong would run past the window instead of returning to its base, or would split an aligned request. Wrap lengths that match and do not match the beat count are both driven, so choosing the wrong path shows up as a wrong `wrap_mode` or as a missing or extra strobe at the window base. Random ready stalls catch a beat that advances without a handshake. A request injected mid-burst with different settings would show up as extra beats or a changed mode if the block did not ignore it. The top of the address space and 1-beat requests cover the shift and mask edges.

// File: rtl/wrap_burst_seq.sv
module wrap_burst_seq #(
  parameter int AW = 26,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [BW:0]   req_beats,
  input  logic [1:0]    mem_width,
  input  logic          wrap_en,
  input  logic [1:0]    wrap_size,
  input  logic          sync_mode,
  input  logic          mem_ready,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          addr_strobe,
  output logic          beat_valid,
  output logic          wrap_mode,
  output logic          done
);
  localparam int MW = BW + 1;

  logic [AW-1:0] word, base_in;
  logic [MW-1:0] beats_m1;
  logic [BW-1:0] mask_in, off_in;
  logic [BW+1:0] nsize;
  logic          native_in;

  always_comb begin
    case (mem_width)
      2'd0:    word = req_addr;
      2'd1:    word = {1'b0, req_addr[AW-1:1]};
      default: word = {2'b00, req_addr[AW-1:2]};
    endcase
  end

  assign beats_m1  = req_beats - 1'b1;
  assign mask_in   = beats_m1[BW-1:0];
  assign base_in   = word & ~{{(AW-BW){1'b0}}, mask_in};
  assign off_in    = word[BW-1:0] & mask_in;
  assign nsize     = (BW+2)'(8) << wrap_size;
  assign native_in = wrap_en && ({1'b0, req_beats} == nsize);

  logic          busy_q, done_q, wrap_q, sync_q, first_q;
  logic [AW-1:0] base_q;
  logic [BW-1:0] pos_q, mask_q, pos_nx;
  logic [MW-1:0] left_q;
  logic          fire;

  assign fire   = busy_q & mem_ready;
  assign pos_nx = (pos_q + 1'b1) & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wrap_q  <= 1'b0;
      sync_q  <= 1'b0;
      first_q <= 1'b0;
      base_q  <= '0;
      pos_q   <= '0;
      mask_q  <= '0;
      left_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid && req_beats != '0) begin
          busy_q  <= 1'b1;
          wrap_q  <= native_in;
          sync_q  <= sync_mode;
          first_q <= 1'b1;
          base_q  <= base_in;
          pos_q   <= off_in;
          mask_q  <= mask_in;
          left_q  <= req_beats;
        end
      end else if (fire) begin
        pos_q   <= pos_nx;
        left_q  <= left_q - 1'b1;
        first_q <= !wrap_q && (pos_nx == '0);
        if (left_q == MW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign beat_valid  = busy_q;
  assign mem_addr    = base_q | {{(AW-BW){1'b0}}, pos_q};
  assign addr_strobe = busy_q & (!sync_q | first_q);
  assign wrap_mode   = busy_q & wrap_q;
  assign done        = done_q;
endmodule

// File: rtl/wrap_burst_seq_chk.sv
module wrap_burst_seq_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ready,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          addr_strobe,
  input logic          beat_valid,
  input logic          wrap_mode,
  input logic          done
);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !mem_ready) |=> (beat_valid && $stable(mem_addr) && $stable(addr_strobe)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(beat_valid && mem_ready)));

  a_r6_linear_continue: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(beat_valid && mem_ready) && beat_valid && !addr_strobe && !wrap_mode)
      |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r9_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> $stable(wrap_mode));
endmodule

bind wrap_burst_seq wrap_burst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .busy(busy),
  .mem_addr(mem_addr), .addr_strobe(addr_strobe), .beat_valid(beat_valid),
  .wrap_mode(wrap_mode), .done(done)
);

// File: tb/wrap_burst_seq_bench.sv
`timescale 1ns/1ps
module wrap_burst_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic [5:0]  req_beats = '0;
  logic [1:0]  mem_width = '0;
  logic        wrap_en = 1'b0;
  logic [1:0]  wrap_size = '0;
  logic        sync_mode = 1'b0;
  logic        mem_ready = 1'b0;
  logic        busy, addr_strobe, beat_valid, wrap_mode, done;
  logic [25:0] mem_addr;

  wrap_burst_seq u_wrap_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_beats(req_beats), .mem_width(mem_width), .wrap_en(wrap_en),
    .wrap_size(wrap_size), .sync_mode(sync_mode), .mem_ready(mem_ready),
    .busy(busy), .mem_addr(mem_addr), .addr_strobe(addr_strobe),
    .beat_valid(beat_valid), .wrap_mode(wrap_mode), .done(done)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [25:0] addr;
    logic        strobe;
    logic        wrap;
    logic        last;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0, done_seen = 0, cyc = 0;
  bit finished = 0, exp_done = 0, exp_low = 0, always_rdy = 1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = always_rdy ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_done) begin
        chk(done === 1'b1 && busy === 1'b0, "R8", "done pulse", {busy, done}, 2'b01);
        exp_done = 0;
        exp_low  = 1;
      end else if (exp_low) begin
        chk(done === 1'b0, "R8", "done width", done, 0);
        exp_low = 0;
        done_seen++;
      end else if (done) begin
        chk(0, "R8", "unexpected done", done, 0);
      end
      if (beat_valid) begin
        if (q.size() == 0) begin
          chk(0, "R9", "beat with nothing expected", mem_addr, 0);
        end else if (mem_ready) begin
          item_t it;
          it = q.pop_front();
          chk(mem_addr === it.addr, it.tag, "address", mem_addr, it.addr);
          chk(addr_strobe === it.strobe, sync_mode_tag(it), "strobe", addr_strobe, it.strobe);
          chk(wrap_mode === it.wrap, it.wrap ? "R2" : "R3", "wrap_mode", wrap_mode, it.wrap);
          if (it.last) exp_done = 1;
        end else begin
          chk(mem_addr === q[0].addr && addr_strobe === q[0].strobe, "R7",
              "stalled beat", mem_addr, q[0].addr);
        end
      end
    end
  end

  bit cur_sync;
  function automatic string sync_mode_tag(item_t it);
    return cur_sync ? "R6" : "R5";
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL R8 watchdog act=0x%0h exp=0x%0h", done_seen, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input logic [25:0] a, input int n, input logic [1:0] w,
                     input bit we, input logic [1:0] ws, input bit sy,
                     input bit junk, input string tag);
    logic [25:0] word, base, msk, off;
    bit native;
    int target;
    word   = a >> w;
    msk    = 26'(n - 1);
    base   = word & ~msk;
    off    = word & msk;
    native = we && ((8 << ws) == n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic [25:0] pos;
      pos       = (off + 26'(i)) & msk;
      it.addr   = base + pos;
      it.strobe = !sy || i == 0 || (!native && pos == 0);
      it.wrap   = native;
      it.last   = (i == n - 1);
      it.tag    = tag;
      q.push_back(it);
    end
    target = done_seen + 1;
    @(negedge clk);
    cur_sync  = sy;
    req_addr  = a;
    req_beats = 6'(n);
    mem_width = w;
    wrap_en   = we;
    wrap_size = ws;
    sync_mode = sy;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      @(negedge clk);
      req_addr  = 26'h155_5555;
      req_beats = 6'd8;
      wrap_en   = 1'b1;
      wrap_size = 2'd0;
      sync_mode = ~sy;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (done_seen == target);
    chk(q.size() == 0, "R8", "beats left over", q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && beat_valid === 1'b0 && done === 1'b0, "R10", "reset state",
        {busy, beat_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid === 1'b0, "R10", "idle after reset", beat_valid, 0);

    always_rdy = 1;
    // R2 native wrap, 8-bit, sync, offset 5
    run(26'h000_0105, 8, 2'd0, 1, 2'd0, 1, 0, "R2");
    always_rdy = 0;
    // R1 R3 split, 16-bit, sync, offset 6, request injected while busy (R9)
    run(26'h000_0A4C, 16, 2'd1, 1, 2'd0, 1, 1, "R3");
    // R1 top of space, 32-bit, async split at last word
    run(26'h3FF_FFFC, 4, 2'd2, 0, 2'd0, 0, 0, "R1");
    // R4 aligned start, sync, no wrap
    run(26'h000_0100, 16, 2'd2, 0, 2'd1, 1, 0, "R4");
    // R2 native async 32-beat wrap
    run(26'h012_3456, 32, 2'd1, 1, 2'd2, 0, 1, "R2");
    // R3 wrap enabled but size mismatch, async
    run(26'h000_0033, 8, 2'd0, 1, 2'd2, 0, 0, "R3");
    // single beat
    run(26'h000_0777, 1, 2'd0, 0, 2'd0, 1, 0, "R4");
    always_rdy = 1;
    run(26'h000_0047, 16, 2'd0, 1, 2'd1, 1, 0, "R2");

    repeat (4) @(negedge clk);
    chk(beat_valid === 1'b0 && busy === 1'b0, "R9", "idle at end", {busy, beat_valid}, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule